// File: doc/BRIEF.md
# Multiplexed Gear-Wheel Code Scanner

This block reads an external multi-turn gear module that shares one narrow data bus among its wheels. It drives a 3-bit select bus that names one address at a time. Address 0 returns a configuration word. Addresses 1 to 7 return the 3-bit code of gear wheels 1 to 7. After every change of the select value, the block waits a fixed settling time before it samples the bus. It then moves on to the next address and wraps after address 7.

Each sample goes into a shadow register. The data bus is brought into the clock domain through a short synchronizer first. When wheel 7 has been captured, all seven wheel codes and the decoded configuration flags are copied to the outputs in the same cycle, and a single-cycle valid pulse marks the new snapshot. Downstream logic therefore always sees one coherent 21-bit picture of the wheels.

A configuration word whose fixed marker bit reads 0 sets a sticky format-error flag. Only reset clears this flag. Dropping the enable input sends the scan back to address 0 and stops all sampling.

Top module: `gearScanTop`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears the outputs: selOut 0, wheelCodes 0, cfgWide 0, cfgSolid 0, snapValid 0, fmtErr 0.
- R2: While enable is high, selOut steps through 0, 1, 2, ..., 7 and then back to 0. Each value is held for exactly SETTLE_CYCLES clock cycles.
- R3: Each address is sampled exactly SETTLE_CYCLES rising edges after the edge that set it. The bus passes through a 2-stage synchronizer, so the sample is the bus value present two edges earlier. Bus values before that point have no effect on the captured code.
- R4: The code of wheel k (1..7) appears in wheelCodes[3k-1:3k-3], so wheel 1 is in bits 2:0 and wheel 7 is in bits 20:18.
- R5: All wheel fields and both configuration flags change only at the rising edge that follows the capture of wheel 7. snapValid is high for exactly that one following cycle. With enable held high, this pulse comes 8*SETTLE_CYCLES+1 edges after enable is raised from address 0.
- R6: From the address-0 sample, data bit 1 gives cfgWide (1 = 14-bit turn count, 0 = 12-bit) and data bit 0 gives cfgSolid (1 = solid shaft).
- R7: If data bit 2 of the address-0 sample is 0, fmtErr is set at that capture edge. It stays set until reset, whatever later samples show.
- R8: While enable is low, selOut is 0 from the next edge on, no sample is taken, and the published outputs hold their values. Raising enable again starts a new full settle period at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Scan enable; low parks the scan at address 0 |
| dataIn | input | 3 | Code returned by the external module for the selected address |
| selOut | output | 3 | Address driven to the external module |
| wheelCodes | output | 21 | Published codes of wheels 1 to 7, wheel 1 in the low bits |
| cfgWide | output | 1 | Published flag: 1 for a 14-bit variant, 0 for 12-bit |
| cfgSolid | output | 1 | Published flag: solid-shaft version |
| snapValid | output | 1 | One-cycle pulse when a new snapshot is published |
| fmtErr | output | 1 | Sticky flag: configuration marker bit read as 0 |

## Verification
The select bus moves at the edge where a capture happens. The captured value reflects the data bus as it was two edges before that capture. The snapshot outputs and snapValid change one edge after the wheel 7 capture, and fmtErr rises at the address-0 capture edge itself. The bench keeps an edge-by-edge model that uses this latency, with its own delay line for the bus, and compares every output at each falling edge. The stand-in for the external module drives the inverted code until a response delay shorter than the settle time has passed, so a sample taken too early yields a wrong code that the comparisons and the end-of-scan code checks catch.

// File: rtl/gearScanPkg.sv
package gearScanPkg;
  // Strobes from the scan control to the capture datapath
  typedef struct packed {
    logic capture;   // sample the synchronized bus into the addressed shadow
    logic publish;   // copy all shadows to the outputs
  } scanStrobe_t;
endpackage

// File: rtl/gearScanCtrl.sv
module gearScanCtrl
  import gearScanPkg::*;
#(
  parameter int NUM_WHEELS    = 7,
  parameter int SETTLE_CYCLES = 3200,
  localparam int SEL_W = $clog2(NUM_WHEELS + 1),
  localparam int CNT_W = $clog2(SETTLE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  output logic [SEL_W-1:0] selAddr,
  output scanStrobe_t      strobes
);
  localparam logic [SEL_W-1:0] LAST_ADDR = SEL_W'(NUM_WHEELS);
  localparam logic [CNT_W-1:0] END_CNT   = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] settleCnt;
  logic             pubPend;
  logic             atEnd;
  logic             lastCapture;

  assign atEnd       = (settleCnt == END_CNT);
  assign lastCapture = enable && atEnd && (selAddr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      selAddr   <= '0;
      settleCnt <= '0;
      pubPend   <= 1'b0;
    end else begin
      pubPend <= lastCapture;
      if (!enable) begin
        selAddr   <= '0;
        settleCnt <= '0;
      end else if (atEnd) begin
        settleCnt <= '0;
        selAddr   <= (selAddr == LAST_ADDR) ? '0 : selAddr + 1'b1;
      end else begin
        settleCnt <= settleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.capture = enable && atEnd;
    strobes.publish = pubPend;
  end

  // R2: address only advances by one or returns home
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (selAddr != $past(selAddr)) |-> (selAddr == '0 || selAddr == $past(selAddr) + 1'b1));

  // R3: a capture never happens in the cycle right after a select change
  p_capture_held_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.capture |-> $stable(selAddr));

  // R8: a low enable parks the scan at address 0
  p_disabled_home_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (selAddr == '0));

  // R5: publishing follows the capture of the last wheel
  p_publish_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.publish |-> ($past(selAddr) == LAST_ADDR && $past(strobes.capture)));

  initial begin
    a_settle_min_r3: assert (SETTLE_CYCLES >= 2);
  end
endmodule

// File: rtl/gearScanPath.sv
module gearScanPath
  import gearScanPkg::*;
#(
  parameter int NUM_WHEELS  = 7,
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W  = $clog2(NUM_WHEELS + 1),
  localparam int SNAP_W = NUM_WHEELS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  scanStrobe_t       strobes,
  input  logic [SEL_W-1:0]  selAddr,
  input  logic [CODE_W-1:0] dataIn,
  output logic [SNAP_W-1:0] wheelCodes,
  output logic              cfgWide,
  output logic              cfgSolid,
  output logic              snapValid,
  output logic              fmtErr
);
  logic [CODE_W-1:0] syncStage [SYNC_STAGES];
  logic [CODE_W-1:0] sampled;
  logic [CODE_W-1:0] shadow [1:NUM_WHEELS];
  logic              cfgWideSh;
  logic              cfgSolidSh;
  logic              cfgCapture;

  // Input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else     syncStage[s] <= dataIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else     syncStage[s] <= syncStage[s-1];
      end
    end
  end

  assign sampled    = syncStage[SYNC_STAGES-1];
  assign cfgCapture = strobes.capture && (selAddr == '0);

  // One shadow per wheel address
  for (genvar k = 1; k <= NUM_WHEELS; k++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)                                           shadow[k] <= '0;
      else if (strobes.capture && selAddr == SEL_W'(k))  shadow[k] <= sampled;
    end
  end

  // Configuration shadow and sticky marker check
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgWideSh  <= 1'b0;
      cfgSolidSh <= 1'b0;
      fmtErr     <= 1'b0;
    end else if (cfgCapture) begin
      cfgWideSh  <= sampled[1];
      cfgSolidSh <= sampled[0];
      if (!sampled[CODE_W-1]) fmtErr <= 1'b1;
    end
  end

  // Coherent publish of the whole snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      wheelCodes <= '0;
      cfgWide    <= 1'b0;
      cfgSolid   <= 1'b0;
      snapValid  <= 1'b0;
    end else begin
      snapValid <= strobes.publish;
      if (strobes.publish) begin
        for (int k = 1; k <= NUM_WHEELS; k++)
          wheelCodes[(k-1)*CODE_W +: CODE_W] <= shadow[k];
        cfgWide  <= cfgWideSh;
        cfgSolid <= cfgSolidSh;
      end
    end
  end

  // R5: the valid pulse lasts one cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    snapValid |=> !snapValid);

  // R5: outputs hold between publishes
  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !snapValid |-> ($stable(wheelCodes) && $stable(cfgWide) && $stable(cfgSolid)));

  // R7: the error flag never clears without reset
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    fmtErr |=> fmtErr);

  // R7: the error flag only rises on a configuration capture
  p_err_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fmtErr) |-> $past(cfgCapture));
endmodule

// File: rtl/gearScanTop.sv
module gearScanTop
  import gearScanPkg::*;
#(
  parameter int NUM_WHEELS    = 7,
  parameter int CODE_W        = 3,
  parameter int SETTLE_CYCLES = 3200,
  parameter int SYNC_STAGES   = 2,
  localparam int SEL_W  = $clog2(NUM_WHEELS + 1),
  localparam int SNAP_W = NUM_WHEELS * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] dataIn,
  output logic [SEL_W-1:0]  selOut,
  output logic [SNAP_W-1:0] wheelCodes,
  output logic              cfgWide,
  output logic              cfgSolid,
  output logic              snapValid,
  output logic              fmtErr
);
  scanStrobe_t strobes;

  gearScanCtrl #(
    .NUM_WHEELS   (NUM_WHEELS),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .selAddr(selOut),
    .strobes(strobes)
  );

  gearScanPath #(
    .NUM_WHEELS (NUM_WHEELS),
    .CODE_W     (CODE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_path (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .selAddr   (selOut),
    .dataIn    (dataIn),
    .wheelCodes(wheelCodes),
    .cfgWide   (cfgWide),
    .cfgSolid  (cfgSolid),
    .snapValid (snapValid),
    .fmtErr    (fmtErr)
  );
endmodule

// File: tb/gearScanTop_test.sv
`timescale 1ns/1ps
module gearScanTop_test;
  localparam int SETTLE   = 24;
  localparam int RESP_DLY = 16;
  localparam int NW       = 7;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [2:0]  dataIn = 3'b000;
  logic [2:0]  selOut;
  logic [20:0] wheelCodes;
  logic        cfgWide, cfgSolid, snapValid, fmtErr;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit started = 0;

  always #10 clk = ~clk;  // 50 MHz

  gearScanTop #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst(rst), .enable(enable), .dataIn(dataIn),
    .selOut(selOut), .wheelCodes(wheelCodes), .cfgWide(cfgWide),
    .cfgSolid(cfgSolid), .snapValid(snapValid), .fmtErr(fmtErr)
  );

  // External module stand-in: index 0 is the configuration word
  logic [2:0] trueVal [8];
  int lastSel = -1;
  int age = 0;
  always @(negedge clk) begin
    if (int'(selOut) != lastSel) begin
      lastSel = int'(selOut);
      age = 0;
    end else if (age < 1000) age++;
    dataIn <= (age >= RESP_DLY) ? trueVal[selOut] : ~trueVal[selOut];
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on every rising edge
  int mSel, mCnt;
  logic [2:0] mShadow [8];
  logic [2:0] mWheel [8];
  logic mWide, mSolid, mValid, mErr, mPend;
  logic [2:0] h1, h2;

  always @(posedge clk) begin
    logic [2:0] smp;
    logic pub;
    started = 1;
    if (rst) begin
      mSel = 0; mCnt = 0; mValid = 0; mErr = 0; mPend = 0;
      mWide = 0; mSolid = 0; h1 = 0; h2 = 0;
      foreach (mShadow[i]) begin mShadow[i] = 0; mWheel[i] = 0; end
    end else begin
      smp = h2; h2 = h1; h1 = dataIn;
      pub = mPend;
      if (pub) begin
        for (int k = 1; k <= NW; k++) mWheel[k] = mShadow[k];
        mWide = mShadow[0][1]; mSolid = mShadow[0][0];
      end
      mPend = 0;
      if (enable) begin
        if (mCnt == SETTLE - 1) begin
          mShadow[mSel] = smp;
          if (mSel == 0 && !smp[2]) mErr = 1;
          if (mSel == NW) mPend = 1;
          mSel = (mSel + 1) % 8;
          mCnt = 0;
        end else mCnt++;
      end else begin
        mSel = 0; mCnt = 0;
      end
      mValid = pub;
    end
  end

  function automatic logic [20:0] packModel();
    logic [20:0] v = '0;
    for (int k = 1; k <= NW; k++) v[(k-1)*3 +: 3] = mWheel[k];
    return v;
  endfunction

  function automatic logic [20:0] packTrue();
    logic [20:0] v = '0;
    for (int k = 1; k <= NW; k++) v[(k-1)*3 +: 3] = trueVal[k];
    return v;
  endfunction

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (started) begin
      chk("R2", "selOut", 32'(selOut), 32'(mSel));
      chk("R4", "wheelCodes", 32'(wheelCodes), 32'(packModel()));
      chk("R6", "cfgWide", 32'(cfgWide), 32'(mWide));
      chk("R6", "cfgSolid", 32'(cfgSolid), 32'(mSolid));
      chk("R5", "snapValid", 32'(snapValid), 32'(mValid));
      chk("R7", "fmtErr", 32'(fmtErr), 32'(mErr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic waitSnap();
    do @(negedge clk); while (!snapValid);
  endtask

  initial begin
    logic [20:0] held;
    int n;
    trueVal[0] = 3'b111;
    for (int k = 1; k <= NW; k++) trueVal[k] = 3'(k);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "selOut", 32'(selOut), 0);
    chk("R1", "wheelCodes", 32'(wheelCodes), 0);
    chk("R1", "cfg", 32'({cfgWide, cfgSolid}), 0);
    chk("R1", "snapValid/fmtErr", 32'({snapValid, fmtErr}), 0);
    rst = 1'b0;

    // R8 idle with enable low, then R5 timing from enable rise
    repeat (5) @(negedge clk);
    chk("R8", "selOut idle", 32'(selOut), 0);
    enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!snapValid && n < 1000);
    chk("R5", "edges to first snapshot", 32'(n), 32'(8*SETTLE + 1));
    chk("R3", "codes after settle", 32'(wheelCodes), 32'(packTrue()));
    chk("R6", "14-bit solid", 32'({cfgWide, cfgSolid}), 32'(2'b11));

    // Second pattern, 12-bit solid
    trueVal[0] = 3'b101;
    for (int k = 1; k <= NW; k++) trueVal[k] = 3'(7 - k) ^ 3'b010;
    waitSnap(); waitSnap();
    chk("R3", "codes pattern B", 32'(wheelCodes), 32'(packTrue()));
    chk("R4", "wheel 7 field", 32'(wheelCodes[20:18]), 32'(trueVal[7]));
    chk("R6", "12-bit solid", 32'({cfgWide, cfgSolid}), 32'(2'b01));

    // R8 disable mid-scan: home address, outputs hold
    repeat (40) @(negedge clk);
    enable = 1'b0;
    held = wheelCodes;
    for (int k = 0; k < 3; k++) trueVal[k+1] = 3'b000;
    repeat (30) @(negedge clk);
    chk("R8", "selOut while disabled", 32'(selOut), 0);
    chk("R8", "held codes", 32'(wheelCodes), 32'(held));
    enable = 1'b1;
    waitSnap(); waitSnap();
    chk("R3", "codes after re-enable", 32'(wheelCodes), 32'(packTrue()));

    // R7 missing marker bit, then sticky
    trueVal[0] = 3'b010;
    waitSnap(); waitSnap();
    chk("R7", "error set", 32'(fmtErr), 1);
    trueVal[0] = 3'b110;
    waitSnap(); waitSnap();
    chk("R7", "error sticky", 32'(fmtErr), 1);
    chk("R6", "14-bit hollow", 32'({cfgWide, cfgSolid}), 32'(2'b10));

    // R1 reset clears the sticky flag
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "fmtErr after reset", 32'(fmtErr), 0);
    chk("R1", "wheelCodes after reset", 32'(wheelCodes), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule